// File: doc/BRIEF.md
# PHY Control-Register Access Master

This block performs single register accesses on the parallel control-register ports of a set of PHYs. One shared command port takes a PHY index, a direction bit, a 16-bit register address and 16-bit write data. The block drives the chosen PHY's address and write-data lines first. It then raises that PHY's read enable or write enable and waits for the PHY's acknowledge to rise. Next it drops the enable and waits for the acknowledge to fall. Only after that full four-phase exchange does it report completion with a one-cycle done pulse, together with the captured read data.

Each PHY port is enabled by a configuration bit, and the block reflects it on a per-PHY select output. A command that names a PHY index beyond the last port, or a port whose select is low, is refused. It completes at once with an error and leaves every PHY line as it was. The default build serves two PHYs. The port count and the field widths are parameters.

Top module: `phy_cr_master`

## Requirements
- R1: `cmd_ready` is high only while no access is in flight; a command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low from the next cycle until the access ends.
- R2: A command whose `cmd_idx` is NUM_PHY or above (2 or 3 by default), or names a PHY whose `phy_sel` bit is 0, gives `rsp_done` and `rsp_err` both high in the cycle right after it is taken, raises no enable, and changes no PHY line.
- R3: The selected PHY's address, and for a write its write data, are driven at least one cycle before its enable rises.
- R4: A write (`cmd_wr`=1) raises only that PHY's write enable; a read (`cmd_wr`=0) raises only its read enable; no PHY ever has both enables high.
- R5: A raised enable stays high until that PHY's acknowledge is sampled high, and is low in the following cycle.
- R6: On a read, the PHY's read data present while acknowledge is high is returned on `rsp_rdata`; `rsp_rdata` then holds its value through writes and errors until the next read completes.
- R7: After the enable drops, the block waits for the acknowledge to be sampled low; `rsp_done` then pulses for exactly one cycle with `rsp_err` low, so an access with acknowledge rise and fall latencies of L cycles each ends 6+2L cycles after acceptance with the bench's PHY model.
- R8: The selected PHY's address and write data do not change while its enable or acknowledge is high.
- R9: The address, write data and enables of a PHY that is not named by a command keep their values during that access.
- R10: `phy_sel[p]` follows configuration bit `sel_cfg[p]` one cycle later and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_cfg | input | NUM_PHY | Per-PHY port enable configuration |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_idx | input | IDX_W | Target PHY index |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error flag, valid with rsp_done |
| rsp_rdata | output | DATA_W | Data of the last completed read |
| phy_sel | output | NUM_PHY | Per-PHY control port select |
| phy_addr | output | NUM_PHY*ADDR_W | Per-PHY address lines, PHY p at bits p*ADDR_W upward |
| phy_wdata | output | NUM_PHY*DATA_W | Per-PHY write data lines |
| phy_rd_en | output | NUM_PHY | Per-PHY read enable |
| phy_wr_en | output | NUM_PHY | Per-PHY write enable |
| phy_ack | input | NUM_PHY | Per-PHY acknowledge |
| phy_rdata | input | NUM_PHY*DATA_W | Per-PHY read data lines |

## Verification
A wrong sequencer state shows at the ports within one or two cycles. An enable may stay high after the acknowledge, or rise before the address is settled. The done pulse may appear while the acknowledge is still high, or `cmd_ready` may return early. Each of these changes the completion latency, which the bench predicts exactly as 6+2L cycles for every swept latency. A wrong port decode shows up in the PHY model's recorded address and data, or as lines that moved on the PHY not addressed. A wrong capture shows up in the returned read value or in a `rsp_rdata` that moves after a write.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
   typedef enum logic [1:0] {
      CR_IDLE     = 2'd0,
      CR_SETUP    = 2'd1,
      CR_WAIT_HI  = 2'd2,
      CR_WAIT_LO  = 2'd3
   } cr_state_t;
endpackage

// File: rtl/phy_cr_lane.sv
// Per-PHY holding registers for the address and write-data lines.
module phy_cr_lane #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_wr,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic [DATA_W-1:0] wdata_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_out  <= '0;
         wdata_out <= '0;
      end else if (load) begin
         addr_out <= addr_in;
         if (load_wr) wdata_out <= wdata_in;
      end
   end
endmodule

// File: rtl/phy_cr_seq.sv
// Four-phase handshake sequencer shared by all PHY ports.
module phy_cr_seq
   import phy_cr_pkg::*;
#(
   parameter int NUM_PHY = 2,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [IDX_W-1:0]   cmd_idx,
   input  logic               cmd_wr,
   input  logic [NUM_PHY-1:0] port_on,
   input  logic [NUM_PHY-1:0] ack,
   output logic               cmd_ready,
   output logic [NUM_PHY-1:0] load,
   output logic               capture,
   output logic [IDX_W-1:0]   cur_idx,
   output logic [NUM_PHY-1:0] rd_en,
   output logic [NUM_PHY-1:0] wr_en,
   output logic               done,
   output logic               err
);
   cr_state_t state;
   logic      cur_wr;
   logic      idx_ok;
   logic      ack_cur;

   always_comb begin
      idx_ok  = 1'b0;
      ack_cur = 1'b0;
      for (int p = 0; p < NUM_PHY; p++) begin
         if (cmd_idx == IDX_W'(p) && port_on[p]) idx_ok = 1'b1;
         if (cur_idx == IDX_W'(p)) ack_cur = ack[p];
      end
   end

   assign cmd_ready = (state == CR_IDLE);
   assign capture   = (state == CR_WAIT_HI) && ack_cur && !cur_wr;

   always_comb begin
      load = '0;
      for (int p = 0; p < NUM_PHY; p++)
         if (cmd_ready && cmd_valid && idx_ok && cmd_idx == IDX_W'(p)) load[p] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= CR_IDLE;
         cur_idx <= '0;
         cur_wr  <= 1'b0;
         rd_en   <= '0;
         wr_en   <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (state)
            CR_IDLE: begin
               if (cmd_valid) begin
                  if (idx_ok) begin
                     cur_idx <= cmd_idx;
                     cur_wr  <= cmd_wr;
                     state   <= CR_SETUP;
                  end else begin
                     done <= 1'b1;
                     err  <= 1'b1;
                  end
               end
            end
            CR_SETUP: begin
               for (int p = 0; p < NUM_PHY; p++) begin
                  if (cur_idx == IDX_W'(p)) begin
                     if (cur_wr) wr_en[p] <= 1'b1;
                     else        rd_en[p] <= 1'b1;
                  end
               end
               state <= CR_WAIT_HI;
            end
            CR_WAIT_HI: begin
               if (ack_cur) begin
                  rd_en <= '0;
                  wr_en <= '0;
                  state <= CR_WAIT_LO;
               end
            end
            CR_WAIT_LO: begin
               if (!ack_cur) begin
                  done  <= 1'b1;
                  state <= CR_IDLE;
               end
            end
            default: state <= CR_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master #(
   parameter int NUM_PHY = 2,
   parameter int IDX_W   = 2,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PHY-1:0]        sel_cfg,
   input  logic                      cmd_valid,
   output logic                      cmd_ready,
   input  logic [IDX_W-1:0]          cmd_idx,
   input  logic                      cmd_wr,
   input  logic [ADDR_W-1:0]         cmd_addr,
   input  logic [DATA_W-1:0]         cmd_wdata,
   output logic                      rsp_done,
   output logic                      rsp_err,
   output logic [DATA_W-1:0]         rsp_rdata,
   output logic [NUM_PHY-1:0]        phy_sel,
   output logic [NUM_PHY*ADDR_W-1:0] phy_addr,
   output logic [NUM_PHY*DATA_W-1:0] phy_wdata,
   output logic [NUM_PHY-1:0]        phy_rd_en,
   output logic [NUM_PHY-1:0]        phy_wr_en,
   input  logic [NUM_PHY-1:0]        phy_ack,
   input  logic [NUM_PHY*DATA_W-1:0] phy_rdata
);
   localparam int MIN_IDX_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;

   if (NUM_PHY < 1) begin : g_bad_num
      $error("NUM_PHY must be at least 1");
   end
   if (IDX_W < MIN_IDX_W) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_PHY");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
      $error("ADDR_W and DATA_W must be positive");
   end

   logic [NUM_PHY-1:0] load;
   logic               capture;
   logic [IDX_W-1:0]   cur_idx;
   logic [DATA_W-1:0]  rdata_cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phy_sel <= '0;
      else        phy_sel <= sel_cfg;
   end

   phy_cr_seq #(.NUM_PHY(NUM_PHY), .IDX_W(IDX_W)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_idx   (cmd_idx),
      .cmd_wr    (cmd_wr),
      .port_on   (phy_sel),
      .ack       (phy_ack),
      .cmd_ready (cmd_ready),
      .load      (load),
      .capture   (capture),
      .cur_idx   (cur_idx),
      .rd_en     (phy_rd_en),
      .wr_en     (phy_wr_en),
      .done      (rsp_done),
      .err       (rsp_err)
   );

   for (genvar p = 0; p < NUM_PHY; p++) begin : g_lane
      phy_cr_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) lane_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load[p]),
         .load_wr   (cmd_wr),
         .addr_in   (cmd_addr),
         .wdata_in  (cmd_wdata),
         .addr_out  (phy_addr[p*ADDR_W +: ADDR_W]),
         .wdata_out (phy_wdata[p*DATA_W +: DATA_W])
      );
   end

   always_comb begin
      rdata_cur = '0;
      for (int p = 0; p < NUM_PHY; p++)
         if (cur_idx == IDX_W'(p)) rdata_cur = phy_rdata[p*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rsp_rdata <= '0;
      else if (capture) rsp_rdata <= rdata_cur;
   end
endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
   parameter int NUM_PHY = 2,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cmd_ready,
   input logic                      rsp_done,
   input logic                      rsp_err,
   input logic [NUM_PHY*ADDR_W-1:0] phy_addr,
   input logic [NUM_PHY*DATA_W-1:0] phy_wdata,
   input logic [NUM_PHY-1:0]        phy_rd_en,
   input logic [NUM_PHY-1:0]        phy_wr_en,
   input logic [NUM_PHY-1:0]        phy_ack
);
   a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ((phy_rd_en | phy_wr_en) != '0) |-> !cmd_ready);

   a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   a_r2_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done);

   a_r4_one_port_active: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phy_rd_en | phy_wr_en));

   for (genvar p = 0; p < NUM_PHY; p++) begin : g_port
      logic en_p;
      assign en_p = phy_rd_en[p] | phy_wr_en[p];

      a_r4_no_dual_enable: assert property (@(posedge clk) disable iff (!rst_n)
         !(phy_rd_en[p] && phy_wr_en[p]));

      a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
         (en_p && !phy_ack[p]) |=> en_p);

      a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
         (en_p && phy_ack[p]) |=> !en_p);

      a_r3_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(en_p) |-> $stable(phy_addr[p*ADDR_W +: ADDR_W]));

      a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
         (en_p || phy_ack[p]) |=> $stable(phy_addr[p*ADDR_W +: ADDR_W]));

      a_r8_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
         (en_p || phy_ack[p]) |=> $stable(phy_wdata[p*DATA_W +: DATA_W]));
   end
endmodule

bind phy_cr_master phy_cr_master_chk #(
   .NUM_PHY (NUM_PHY),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .rsp_done  (rsp_done),
   .rsp_err   (rsp_err),
   .phy_addr  (phy_addr),
   .phy_wdata (phy_wdata),
   .phy_rd_en (phy_rd_en),
   .phy_wr_en (phy_wr_en),
   .phy_ack   (phy_ack)
);

// File: tb/phy_cr_master_tb_top.sv
module phy_cr_master_tb_top;
   localparam int NP = 2;
   localparam int IW = 2;
   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] sel_cfg = '0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [IW-1:0] cmd_idx = '0;
   logic          cmd_wr = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          rsp_done, rsp_err;
   logic [DW-1:0] rsp_rdata;
   logic [NP-1:0] phy_sel;
   logic [NP*AW-1:0] phy_addr;
   logic [NP*DW-1:0] phy_wdata;
   logic [NP-1:0] phy_rd_en, phy_wr_en;
   logic [NP-1:0] phy_ack;
   logic [NP*DW-1:0] phy_rdata;

   int checks = 0;
   int errors = 0;
   int lat = 0;

   always #10 clk = ~clk;

   phy_cr_master #(.NUM_PHY(NP), .IDX_W(IW), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_cfg(sel_cfg),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_idx(cmd_idx),
      .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .phy_sel(phy_sel), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
      .phy_rd_en(phy_rd_en), .phy_wr_en(phy_wr_en),
      .phy_ack(phy_ack), .phy_rdata(phy_rdata)
   );

   function automatic logic [DW-1:0] rd_val(int p, logic [AW-1:0] a);
      return (a ^ 16'h5A3C) + 16'(p * 257);
   endfunction

   // PHY models: acknowledge after lat cycles, release after lat cycles
   int            en_rises [NP];
   logic [AW-1:0] seen_addr [NP];
   logic [DW-1:0] seen_wdata [NP];
   logic          seen_wr [NP];
   int            viol = 0;

   for (genvar p = 0; p < NP; p++) begin : g_model
      int            cnt;
      logic          en_q;
      logic [AW-1:0] a_q;
      logic [DW-1:0] d_q;
      logic          ack_r;
      wire  [AW-1:0] a_now = phy_addr[p*AW +: AW];
      wire  [DW-1:0] d_now = phy_wdata[p*DW +: DW];
      wire           en_now = phy_rd_en[p] | phy_wr_en[p];
      assign phy_ack[p] = ack_r;
      assign phy_rdata[p*DW +: DW] = rd_val(p, a_now);
      initial en_rises[p] = 0;
      always @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= 0; en_q <= 1'b0; ack_r <= 1'b0; a_q <= '0; d_q <= '0;
         end else begin
            en_q <= en_now;
            a_q  <= a_now;
            d_q  <= d_now;
            if (phy_rd_en[p] && phy_wr_en[p]) viol <= viol + 1;            // R4
            if (en_now && !en_q) begin
               en_rises[p] <= en_rises[p] + 1;
               if (a_now != a_q) viol <= viol + 1;                          // R3
            end
            if ((en_q || ack_r) && (a_now != a_q || d_now != d_q)) viol <= viol + 1; // R8
            if (en_now && !ack_r) begin
               if (cnt >= lat) begin
                  ack_r <= 1'b1; cnt <= 0;
                  seen_addr[p]  <= a_now;
                  seen_wdata[p] <= d_now;
                  seen_wr[p]    <= phy_wr_en[p];
               end else cnt <= cnt + 1;
            end else if (!en_now && ack_r) begin
               if (cnt >= lat) begin ack_r <= 1'b0; cnt <= 0; end
               else cnt <= cnt + 1;
            end
         end
      end
   end

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic run_cmd(int idx, bit wr, logic [AW-1:0] a, logic [DW-1:0] d,
                          output bit e, output logic [DW-1:0] rd, output int cyc,
                          output bit rdy_mid);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_idx = IW'(idx); cmd_wr = wr; cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      rdy_mid = cmd_ready;
      cyc = 1;
      while (!rsp_done && cyc < 300) begin
         @(negedge clk);
         cyc++;
      end
      e  = rsp_err;
      rd = rsp_rdata;
      @(negedge clk);
      check(rsp_done == 1'b0, "R7", "done longer than one cycle", rsp_done, 0);
   endtask

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      bit e, rdy;
      logic [DW-1:0] rd, last_rd;
      int cyc;
      logic [AW-1:0] other_a;
      int rises0, rises1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
      check(phy_rd_en == '0 && phy_wr_en == '0, "R4", "enables after reset", {phy_rd_en, phy_wr_en}, 0);
      check(rsp_done == 1'b0, "R7", "done after reset", rsp_done, 0);
      check(phy_sel == '0, "R10", "select after reset", phy_sel, 0);

      sel_cfg = 2'b11;
      @(negedge clk);
      check(phy_sel == 2'b11, "R10", "select follows config", phy_sel, 3);

      last_rd = '0;
      for (int p = 0; p < NP; p++) begin
         for (int w = 0; w < 2; w++) begin
            for (int l = 0; l < 4; l++) begin
               logic [AW-1:0] a;
               logic [DW-1:0] d;
               a = 16'h1008 + 16'(l * 256) + 16'(p * 16) + 16'(w);
               d = 16'h0E21 + 16'(l * 3 + p * 64 + w);
               lat = l;
               other_a = phy_addr[(1-p)*AW +: AW];
               rises0 = en_rises[1-p];
               run_cmd(p, w[0], a, d, e, rd, cyc, rdy);
               check(rdy == 1'b0, "R1", "ready while busy", rdy, 0);
               check(e == 1'b0, "R7", "no error on valid access", e, 0);
               check(cyc == 6 + 2 * l, "R7", "completion latency", cyc, 6 + 2 * l);
               check(seen_addr[p] == a, "R3", "address seen at ack", seen_addr[p], a);
               check(seen_wr[p] == w[0], "R4", "enable kind", seen_wr[p], w);
               if (w == 1) begin
                  check(seen_wdata[p] == d, "R3", "write data seen at ack", seen_wdata[p], d);
                  check(rd == last_rd, "R6", "read data held over write", rd, last_rd);
               end else begin
                  check(rd == rd_val(p, a), "R6", "read data", rd, rd_val(p, a));
                  last_rd = rd;
               end
               check(phy_addr[(1-p)*AW +: AW] == other_a, "R9", "other PHY address", phy_addr[(1-p)*AW +: AW], other_a);
               check(en_rises[1-p] == rises0, "R9", "other PHY enable", en_rises[1-p], rises0);
            end
         end
      end
      lat = 1;

      // out-of-range indices
      for (int idx = NP; idx < 4; idx++) begin
         rises0 = en_rises[0]; rises1 = en_rises[1];
         other_a = phy_addr[AW-1:0];
         run_cmd(idx, 1'b1, 16'hBEEF, 16'h1234, e, rd, cyc, rdy);
         check(e == 1'b1, "R2", "error for bad index", e, 1);
         check(cyc == 1, "R2", "immediate completion", cyc, 1);
         check(en_rises[0] == rises0 && en_rises[1] == rises1, "R2", "no enable on bad index",
               en_rises[0] + en_rises[1], rises0 + rises1);
         check(phy_addr[AW-1:0] == other_a, "R2", "no line change", phy_addr[AW-1:0], other_a);
         check(rd == last_rd, "R6", "read data held over error", rd, last_rd);
      end

      // unselected PHY
      sel_cfg = 2'b01;
      @(negedge clk);
      check(phy_sel == 2'b01, "R10", "select cleared", phy_sel, 1);
      rises1 = en_rises[1];
      other_a = phy_addr[AW +: AW];
      run_cmd(1, 1'b0, 16'h2222, 16'h0, e, rd, cyc, rdy);
      check(e == 1'b1, "R2", "error for unselected PHY", e, 1);
      check(cyc == 1, "R2", "unselected completes at once", cyc, 1);
      check(en_rises[1] == rises1, "R2", "no enable on unselected", en_rises[1], rises1);
      check(phy_addr[AW +: AW] == other_a, "R2", "unselected lines unchanged", phy_addr[AW +: AW], other_a);

      // selected PHY still works
      run_cmd(0, 1'b0, 16'h0777, 16'h0, e, rd, cyc, rdy);
      check(e == 1'b0 && rd == rd_val(0, 16'h0777), "R6", "read after reselect", rd, rd_val(0, 16'h0777));

      check(viol == 0, "R8", "PHY model protocol violations", viol, 0);
      finish_run();
   end
endmodule